// File: doc/BRIEF.md
# Shared-Line Driver Enable Sequencer

This block owns the output enables of up to eight sources that share a single three-state line. A select input names the source that should own the line, and a global enable gates the whole arrangement. The block drives a one-hot enable vector so that at most one source is ever driving, and it raises an idle flag whenever no source is driving and the line therefore floats to an undefined value.

Ownership changes are break-before-make. When the selected source changes, the current owner's enable is removed on the next clock. The block then holds all enables low for a parameterised dead interval of `DEAD_CYCLES` clocks before it enables the newly selected source. The dead interval is sized by the integrator to cover the worst-case difference between driver turn-off and turn-on times, plus skew on the enable wires. If the select moves again during the dead interval, the interval restarts, and the most recent select wins. Dropping the global enable clears every enable on the next clock. Raising it again costs a full dead interval before any source is enabled. `NSRC` must be a power of two, so that every select code names a real source.

Top module: `bus_owner_seq`

## Requirements
- R1: With the global enable high and the select held at value s after the dead interval has passed, exactly bit s of `drv_en` is high (bit i belongs to select code i), and it stays high for as long as the select and the global enable are unchanged.
- R2: `drv_en` is always either all-zero or one-hot.
- R3: `line_idle` is high exactly in the cycles where every bit of `drv_en` is low.
- R4: If the select is sampled differing from the current owner at a clock edge, `drv_en` is all-zero after that edge. One non-zero enable value never changes directly into a different non-zero value.
- R5: After a select change is sampled at edge E0 while a source drives, `drv_en` stays all-zero for exactly `DEAD_CYCLES` cycles. After edge E0+`DEAD_CYCLES` it equals the one-hot code of the new select.
- R6: A select change sampled during the dead interval, including on its final cycle, restarts the full interval from that edge. The last sampled select is the one enabled.
- R7: With the global enable low, `drv_en` is all-zero from the next edge on, whatever the select does.
- R8: When the global enable is first sampled high at edge E0 while nothing drives, `drv_en` stays all-zero for `DEAD_CYCLES` cycles. It becomes one-hot after edge E0+`DEAD_CYCLES`.
- R9: During reset (`rst_n` low, asynchronous), `drv_en` is all-zero and `line_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Global enable; low forces every source off |
| sel | input | $clog2(NSRC) | Code of the source that should own the line |
| drv_en | output | NSRC | One-hot (or zero) output enables, bit i for source i |
| line_idle | output | 1 | High when no source drives the line |

## Verification
Two functions can meet at the same clock edge. The first case is the global enable falling in the same cycle as a select change. The bench changes both at the same point and expects the global enable to win: the enables are cleared and no dead-interval countdown toward the new select survives. The second case is a select change that lands on the final cycle of a dead interval, the very cycle in which the pending source would have been enabled. The bench places that change exactly there and judges the outcome by the absence of the old target's enable and by a fresh, full-length gap before the newest source comes on.

// File: rtl/bus_owner_seq.sv
module bus_owner_seq #(
  parameter int NSRC        = 8,
  parameter int DEAD_CYCLES = 4,
  localparam int SEL_W      = $clog2(NSRC),
  localparam int CNT_W      = $clog2(DEAD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [SEL_W-1:0] sel,
  output logic [NSRC-1:0]  drv_en,
  output logic             line_idle
);

  logic             own_vld;
  logic [SEL_W-1:0] own;
  logic             in_gap;
  logic [SEL_W-1:0] tgt;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own     <= '0;
      in_gap  <= 1'b0;
      tgt     <= '0;
      cnt     <= '0;
    end else if (!go) begin
      own_vld <= 1'b0;
      in_gap  <= 1'b0;
    end else if (own_vld) begin
      if (sel != own) begin
        own_vld <= 1'b0;
        in_gap  <= 1'b1;
        tgt     <= sel;
        cnt     <= CNT_W'(DEAD_CYCLES);
      end
    end else if (!in_gap || sel != tgt) begin
      in_gap <= 1'b1;
      tgt    <= sel;
      cnt    <= CNT_W'(DEAD_CYCLES);
    end else if (cnt == CNT_W'(1)) begin
      own_vld <= 1'b1;
      own     <= tgt;
      in_gap  <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_en
    assign drv_en[i] = own_vld && (own == SEL_W'(i));
  end

  assign line_idle = !own_vld;

endmodule

module bus_owner_seq_chk #(
  parameter int NSRC        = 8,
  parameter int DEAD_CYCLES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic [NSRC-1:0] drv_en,
  input logic            line_idle
);
  localparam int ZW = $clog2(DEAD_CYCLES + 2) + 1;
  logic [ZW-1:0] zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              zrun <= '0;
    else if (|drv_en)        zrun <= '0;
    else if (zrun != '1)     zrun <= zrun + 1'b1;
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en));

  assert_idle_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle == (drv_en == '0));

  assert_no_direct_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|$past(drv_en)) && (|drv_en)) |-> drv_en == $past(drv_en));

  assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|drv_en) && zrun != '0) |-> zrun >= ZW'(DEAD_CYCLES));

  assert_go_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> drv_en == '0);

  assert_reset_off_R9: assert property (@(posedge clk)
    !rst_n |-> (drv_en == '0 && line_idle));
endmodule

bind bus_owner_seq bus_owner_seq_chk #(.NSRC(NSRC), .DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .drv_en(drv_en), .line_idle(line_idle)
);

// File: tb/bus_owner_seq_tb.sv
`timescale 1ns/1ps
module bus_owner_seq_tb;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] drv_en;
  logic       line_idle;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_owner_seq #(.NSRC(8), .DEAD_CYCLES(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .sel(sel),
    .drv_en(drv_en), .line_idle(line_idle)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic g, input logic [2:0] s);
    @(negedge clk); go = g; sel = s;
  endtask

  task automatic expect_en(input logic [7:0] exp, input string tag);
    checks++;
    if (drv_en !== exp) begin
      fails++;
      $display("FAIL %s drv_en=%b expected %b", tag, drv_en, exp);
    end
    checks++;
    if (line_idle !== (exp == 8'd0)) begin
      fails++;
      $display("FAIL R3 line_idle=%b expected %b", line_idle, exp == 8'd0);
    end
  endtask

  task automatic gap_then(input logic [2:0] s, input string tag);
    for (int k = 0; k < D; k++) begin
      tick();
      expect_en(8'd0, tag);
    end
    tick();
    expect_en(8'd1 << s, tag);
  endtask

  task automatic t_reset();
    #2;
    expect_en(8'd0, "R9");
    tick();
    expect_en(8'd0, "R9");
  endtask

  task automatic t_startup();
    drive(1'b0, 3'd2);
    rst_n = 1'b1;
    repeat (3) tick();
    expect_en(8'd0, "R7");
    drive(1'b1, 3'd2);
    gap_then(3'd2, "R8");
    repeat (5) tick();
    expect_en(8'd1 << 2, "R1");
  endtask

  task automatic t_switch();
    drive(1'b1, 3'd5);
    tick();
    expect_en(8'd0, "R4");
    for (int k = 1; k < D; k++) begin
      tick();
      expect_en(8'd0, "R5");
    end
    tick();
    expect_en(8'd1 << 5, "R5");
  endtask

  task automatic t_restart();
    drive(1'b1, 3'd1);
    tick(); tick();
    expect_en(8'd0, "R6");
    drive(1'b1, 3'd6);
    gap_then(3'd6, "R6");
    drive(1'b1, 3'd0);
    for (int k = 0; k < D; k++) tick();
    expect_en(8'd0, "R6");
    drive(1'b1, 3'd7);
    tick();
    expect_en(8'd0, "R6");
    for (int k = 1; k < D; k++) begin
      tick();
      expect_en(8'd0, "R6");
    end
    tick();
    expect_en(8'd1 << 7, "R6");
  endtask

  task automatic t_go_drop();
    drive(1'b0, 3'd3);
    tick();
    expect_en(8'd0, "R7");
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 3'(k + 4));
      tick();
      expect_en(8'd0, "R7");
    end
    drive(1'b1, 3'd3);
    gap_then(3'd3, "R8");
  endtask

  task automatic t_hold_and_zero();
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 3'd3);
      tick();
      expect_en(8'd1 << 3, "R1");
    end
    drive(1'b1, 3'd0);
    tick();
    expect_en(8'd0, "R4");
    for (int k = 1; k < D; k++) tick();
    expect_en(8'd0, "R5");
    tick();
    expect_en(8'd1, "R1");
  endtask

  initial begin
    t_reset();
    t_startup();
    t_switch();
    t_restart();
    t_go_drop();
    t_hold_and_zero();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule